// File: doc/BRIEF.md
# External Interrupt Pin Edge Detector

This block watches one asynchronous external interrupt pin and raises a sticky interrupt request flag when the pin shows a qualifying waveform. A 4-bit control register configures it. The register gates the pin input on or off and picks the active polarity. It chooses whether only the active edge counts or whether both edges count. It also decides whether the pin is forwarded to a timer-control gate. The pin first passes through a multi-flop synchroniser.

The active polarity also sets which pin level a software poll reads as true. The block turns the synchronised pin into an "active level": high when the input is enabled and the pin sits at its active level, low otherwise. Edges are changes of this active level. Rewriting the polarity or enable bits can therefore raise the request flag on its own, exactly as a pin edge would. The flag stays set until software pulses the clear strobe.

Top module: `extint_edge_det`

## Requirements
- R1: After a synchronous reset, the control read-back is 0000 and the request flag, poll output and timer gate are all 0.
- R2: When wr_en is 1 at a clock edge, wr_data is loaded into the control register. With wr_en at 0 the register is unchanged. rd_data shows the register contents in every cycle.
- R3: Control bit 3 enables the pin input. When it is 0, pin activity never sets the request flag, and poll_level reads 0.
- R4: With bit 1 = 0 (single-edge mode), only the active edge sets the flag. Bit 2 = 0 makes that a falling edge and bit 2 = 1 makes it a rising edge.
- R5: With bit 1 = 1 (dual-edge mode), every transition of the enabled, synchronised pin sets the flag, whatever the value of bit 2.
- R6: With the input enabled, poll_level is 1 when the synchronised pin is low (bit 2 = 0) or high (bit 2 = 1), and 0 otherwise.
- R7: tmr_gate follows the synchronised pin when both bit 0 and bit 3 are 1, and is 0 otherwise.
- R8: With the default two synchroniser stages, a pin change shows on irq_flag, poll_level and tmr_gate at the third rising clock edge after it.
- R9: The flag stays set until flag_clr is sampled high. If a clear and a new edge fall in the same cycle, the flag remains set.
- R10: A write that changes bit 2 or bit 3 so that the active level changes is treated as an edge under the current mode. The flag then sets at the clock edge after the one that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_async | input | 1 | Raw external interrupt pin |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 4 | Control write data: [3] input enable, [2] polarity, [1] dual edge, [0] timer gate enable |
| rd_data | output | 4 | Control register read-back |
| flag_clr | input | 1 | Request flag clear strobe |
| irq_flag | output | 1 | Sticky interrupt request flag |
| poll_level | output | 1 | Active-level indication for software polling |
| tmr_gate | output | 1 | Pin forwarded to the timer-control path |

## Verification
The embedded assertions check several properties on every cycle. The flag holds when no clear arrives. The flag never sets without a change in the active level. A disabled input yields a zero poll output. A disabled gate stays low. The control register stays stable without a write. Only the bench's scenarios can show the rest: the exact three-edge latency, which edge counts for each polarity and mode, the clear-versus-edge priority, and flags raised by control rewrites. The bench steps a reference model through every combination of edge mode and polarity under directed and pseudo-random pin patterns.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int CTRL_W = 4;

  // bit positions of the control register
  localparam int BIT_TMR  = 0;
  localparam int BIT_BOTH = 1;
  localparam int BIT_POL  = 2;
  localparam int BIT_EN   = 3;

  typedef struct packed {
    logic in_en;      // [3]
    logic pol_high;   // [2]
    logic both_edges; // [1]
    logic tmr_en;     // [0]
  } extint_ctrl_t;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/extint_ctrl_reg.sv
module extint_ctrl_reg
  import extint_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output extint_ctrl_t      ctrl
);
  extint_ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= extint_ctrl_t'(wr_data);
  end

  assign ctrl = ctrl_q;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl_q)); // R2
endmodule

// File: rtl/extint_edge_core.sv
module extint_edge_core
  import extint_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  extint_ctrl_t ctrl,
  input  logic         pin_s,
  input  logic         flag_clr,
  output logic         irq_flag,
  output logic         poll_level,
  output logic         tmr_gate
);
  logic lvl_now, lvl_q, evt, flag_q, tmr_q;

  // active level: forced low when the input is disabled
  always_comb lvl_now = ctrl.in_en & (pin_s == ctrl.pol_high);

  always_comb begin
    if (ctrl.both_edges) evt = lvl_now ^ lvl_q;
    else                 evt = lvl_now & ~lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      tmr_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      lvl_q <= lvl_now;
      tmr_q <= ctrl.tmr_en & ctrl.in_en & pin_s;
      if (evt)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign irq_flag   = flag_q;
  assign poll_level = lvl_q;
  assign tmr_gate   = tmr_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q); // R9
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && (lvl_now == lvl_q)) |=> !flag_q); // R4
  AST_DISABLED_NO_POLL: assert property (@(posedge clk) disable iff (rst)
    !ctrl.in_en |=> !poll_level); // R3
  AST_TMR_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.tmr_en && ctrl.in_en) |=> !tmr_gate); // R7
endmodule

// File: rtl/extint_edge_det.sv
module extint_edge_det
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_async,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  input  logic              flag_clr,
  output logic              irq_flag,
  output logic              poll_level,
  output logic              tmr_gate
);
  extint_ctrl_t ctrl;
  logic         pin_s;

  extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_async),
    .q   (pin_s)
  );

  extint_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl)
  );

  extint_edge_core u_core (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .pin_s      (pin_s),
    .flag_clr   (flag_clr),
    .irq_flag   (irq_flag),
    .poll_level (poll_level),
    .tmr_gate   (tmr_gate)
  );

  assign rd_data = ctrl;
endmodule

// File: tb/extint_edge_det_tb.sv
`timescale 1ns/1ps
module extint_edge_det_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_async = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic       flag_clr = 1'b0;
  logic [3:0] rd_data;
  logic       irq_flag, poll_level, tmr_gate;

  always #2.5 clk = ~clk;

  extint_edge_det u_dut (
    .clk(clk), .rst(rst), .pin_async(pin_async), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .flag_clr(flag_clr),
    .irq_flag(irq_flag), .poll_level(poll_level), .tmr_gate(tmr_gate)
  );

  typedef struct {
    logic       f;
    logic       p;
    logic       t;
    logic [3:0] r;
    string      tag;
  } exp_t;
  exp_t sb[$];

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference model state
  logic       m_s1 = 0, m_s2 = 0, m_lvl = 0, m_flag = 0, m_tmr = 0;
  logic [3:0] m_ctrl = 0;
  logic       pin_now = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic step(input logic p, input logic w, input logic [3:0] d,
                      input logic c, input logic r, input string tag);
    logic lvl, ev;
    exp_t e;
    @(negedge clk);
    pin_async = p; wr_en = w; wr_data = d; flag_clr = c; rst = r;
    pin_now = p;
    @(posedge clk);
    if (r) begin
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_flag = 0; m_tmr = 0; m_ctrl = 0;
    end else begin
      // active level from the requirements: enabled and pin at chosen level
      lvl = m_ctrl[3] && (m_s2 == m_ctrl[2]);
      if (m_ctrl[1]) ev = (lvl != m_lvl);
      else           ev = (lvl && !m_lvl);
      m_flag = ev ? 1'b1 : (c ? 1'b0 : m_flag);
      m_tmr  = m_ctrl[0] & m_ctrl[3] & m_s2;
      m_lvl  = lvl;
      m_s2   = m_s1;
      m_s1   = p;
      if (w) m_ctrl = d;
    end
    e.f = m_flag; e.p = m_lvl; e.t = m_tmr; e.r = m_ctrl; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(pin_now, 0, 4'h0, 0, 0, tag);
  endtask

  task automatic wr(input logic [3:0] d, input string tag);
    step(pin_now, 1, d, 0, 0, tag);
  endtask

  task automatic clr(input string tag);
    step(pin_now, 0, 4'h0, 1, 0, tag);
  endtask

  task automatic pin(input logic p, input int hold, input string tag);
    step(p, 0, 4'h0, 0, 0, tag);
    idle(hold, tag);
  endtask

  // monitor / comparator
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      compared++;
      if (irq_flag !== e.f || poll_level !== e.p || tmr_gate !== e.t || rd_data !== e.r) begin
        mismatched++;
        $display("FAIL %s: flag/poll/tmr/rd actual %b/%b/%b/%h expected %b/%b/%b/%h",
                 e.tag, irq_flag, poll_level, tmr_gate, rd_data, e.f, e.p, e.t, e.r);
      end
    end
  end

  initial begin
    // R1 reset
    for (int i = 0; i < 3; i++) step(0, 0, 4'h0, 0, 1, "R1");
    idle(2, "R1");

    // R2 write and read-back; wr_data ignored without wr_en
    wr(4'b1010, "R2");
    step(pin_now, 0, 4'b0101, 0, 0, "R2");
    idle(2, "R2");
    wr(4'b0000, "R2");

    // R3 disabled input: pin activity does nothing
    pin(1, 4, "R3"); pin(0, 4, "R3");
    wr(4'b0110, "R3");
    pin(1, 4, "R3"); pin(0, 4, "R3");
    wr(4'b0011, "R3 R7");
    pin(1, 4, "R3 R7"); pin(0, 4, "R3 R7");

    // R8 latency: rising edge, single mode, gate on
    wr(4'b1101, "R8");
    idle(3, "R8");
    clr("R8");
    pin(1, 1, "R8");
    idle(2, "R8");

    // R9 clear vs simultaneous edge
    pin(0, 3, "R9");
    clr("R9");
    step(1, 0, 4'h0, 0, 0, "R9");
    idle(1, "R9");
    step(1, 0, 4'h0, 1, 0, "R9");   // edge arrives on this edge with clr
    idle(1, "R9");
    clr("R9");
    idle(2, "R9");

    // R10 polarity rewrite raises flag
    pin(0, 3, "R10");
    wr(4'b1100, "R10");
    idle(2, "R10");
    clr("R10");
    wr(4'b1000, "R10");             // active level 0 -> 1
    idle(2, "R10");
    clr("R10");
    wr(4'b0000, "R10");
    clr("R10");
    wr(4'b1000, "R10");             // enabling with pin low
    idle(2, "R10");
    clr("R10");
    wr(4'b1010, "R10");
    clr("R10");
    wr(4'b0010, "R10");             // disabling in dual mode drops level
    idle(2, "R10");

    // every combination of polarity and edge mode
    for (int pol = 0; pol < 2; pol++) begin
      for (int both = 0; both < 2; both++) begin
        string tg;
        tg = both ? "R5 R6 R7" : "R4 R6 R7";
        wr({1'b1, pol[0], both[0], 1'b1}, tg);
        idle(3, tg);
        clr(tg);
        pin(1, 4, tg); clr(tg);
        pin(0, 4, tg); clr(tg);
        pin(1, 4, tg);
        pin(0, 4, tg); clr(tg);
        for (int k = 0; k < 40; k++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          step(lf[0], 0, 4'h0, lf[5] & lf[9], 0, tg);
        end
      end
    end

    idle(2, "R2");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule